// File: doc/BRIEF.md
# Dual-Control Register Bank on Clear-Only Storage

This block gives a bank of data registers that each behave as a D flip-flop with both an asynchronous set and an asynchronous reset. The physical storage is built only from flops that have an asynchronous clear; none of them has a preset. A single polarity latch is shared by the whole bank. An XOR on each flop's data input and another on its output reverse the stored sense whenever the latch holds the inverting state.

Either control clears every physical flop. The latch records which kind of event came last: a set leaves it inverting, so a cleared flop reads as 1, and a reset leaves it direct, so a cleared flop reads as 0. When both controls are low, each rising clock edge loads the data input. The XOR on the input makes the loaded value come out unchanged, whatever the latch holds.

A design that needs many set/reset registers on a fabric without presets can use this bank. All registers in the bank share the same two control lines.

Top module: `setreset_bank_emu`

## Requirements
- R1: While `set_i` is high, every bit of `q_o` reads 1 within the same clock phase, without waiting for a clock edge.
- R2: While `reset_i` is high and `set_i` is low, every bit of `q_o` reads 0 at once, without waiting for a clock edge.
- R3: While both `set_i` and `reset_i` are high, `q_o` reads all ones, so set wins. If set then falls while reset stays high, `q_o` becomes all zeros.
- R4: With both controls low, a rising clock edge loads `d_i` into `q_o`. This holds after a set (inverting polarity) and after a reset (direct polarity).
- R5: After a control is released, and whenever `d_i` changes between edges, `q_o` keeps its value until the next rising edge.
- R6: When both controls pulse inside one clock period, the later pulse decides `q_o`. Reset followed by set gives all ones, and set followed by reset gives all zeros.
- R7: `qb_o` is always the bitwise complement of `q_o`.
- R8: Rising clock edges that occur while either control is high do not load `d_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock for data loading |
| set_i | input | 1 | Asynchronous set for the whole bank, active high, wins over reset |
| reset_i | input | 1 | Asynchronous reset for the whole bank, active high |
| d_i | input | WIDTH | Data to load on a rising edge |
| q_o | output | WIDTH | Emulated register outputs |
| qb_o | output | WIDTH | Complement of `q_o` |

## Verification
A polarity latch that holds the wrong state shows up at once as an inverted `q_o`. The error appears in the same phase as the set or reset that should have fixed the polarity, and it lasts until the next edge that loads data. The error also touches `qb_o`. A missing input XOR is subtler: `q_o` stays right after a reset, but after a set every loaded word comes out inverted one edge later. For this reason loads are checked under both polarities. A clear that is not fanned out to every bit, or a wrong priority, shows up at the ports within one time step of the control change. The bench checks `q_o` right after each control edge and again after each release.

// File: rtl/spr_pkg.sv
package spr_pkg;

    // Sense stored in the shared polarity latch
    typedef enum logic {
        POL_DIRECT = 1'b0,
        POL_INVERT = 1'b1
    } pol_e;

    // Control pair seen by the latch
    typedef struct packed {
        logic set;
        logic rst;
    } ctl_t;

    localparam int unsigned SPR_DEF_WIDTH = 8;

    function automatic logic pol_bit(input pol_e p);
        return (p == POL_INVERT);
    endfunction

    // XOR wrapping used on both sides of a physical flop
    function automatic logic pol_apply(input logic b, input pol_e p);
        return b ^ pol_bit(p);
    endfunction

endpackage

// File: rtl/spr_pol_latch.sv
module spr_pol_latch
    import spr_pkg::*;
(
    input  ctl_t ctl_i,
    output pol_e pol_o
);
    pol_e pol_q;

    // Level-sensitive SR element; set has priority
    always_latch begin
        if (ctl_i.set)
            pol_q = POL_INVERT;
        else if (ctl_i.rst)
            pol_q = POL_DIRECT;
    end

    assign pol_o = pol_q;
endmodule

// File: rtl/spr_clr_flop.sv
module spr_clr_flop (
    input  logic clk_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    logic q_r;

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i)
            q_r <= 1'b0;
        else
            q_r <= d_i;
    end

    assign q_o = q_r;

    // R8
    cleared_hold_chk: assert property (@(posedge clk_i) disable iff (!clr_i)
        clr_i |-> (q_r == 1'b0));
endmodule

// File: rtl/spr_bit_slice.sv
module spr_bit_slice
    import spr_pkg::*;
(
    input  logic clk_i,
    input  logic clr_i,
    input  pol_e pol_i,
    input  logic d_i,
    output logic q_o,
    output logic qb_o
);
    logic phys_d;
    logic phys_q;

    assign phys_d = pol_apply(d_i, pol_i);

    spr_clr_flop u_ff (
        .clk_i (clk_i),
        .clr_i (clr_i),
        .d_i   (phys_d),
        .q_o   (phys_q)
    );

    assign q_o  = pol_apply(phys_q, pol_i);
    assign qb_o = pol_apply(~phys_q, pol_i);
endmodule

// File: rtl/setreset_bank_emu.sv
module setreset_bank_emu
    import spr_pkg::*;
#(
    parameter int unsigned WIDTH = SPR_DEF_WIDTH
) (
    input  logic             clk_i,
    input  logic             set_i,
    input  logic             reset_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] qb_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    ctl_t ctl;
    pol_e pol;
    logic clr_any;

    assign ctl.set = set_i;
    assign ctl.rst = reset_i;

    // One physical clear serves both controls
    assign clr_any = set_i | reset_i;

    spr_pol_latch u_pol (
        .ctl_i (ctl),
        .pol_o (pol)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        spr_bit_slice u_slice (
            .clk_i (clk_i),
            .clr_i (clr_any),
            .pol_i (pol),
            .d_i   (d_i[i]),
            .q_o   (q_o[i]),
            .qb_o  (qb_o[i])
        );
    end

    // R1
    set_ones_chk: assert property (@(posedge clk_i) disable iff (!set_i)
        set_i |-> (q_o == ALL_ONES));

    // R2
    reset_zeros_chk: assert property (@(posedge clk_i) disable iff (set_i)
        reset_i |-> (q_o == '0));

    // R7
    always @(negedge clk_i) begin
        compl_chk: assert (qb_o == ~q_o);
    end
endmodule

// File: tb/sim_setreset_bank_emu.sv
module sim_setreset_bank_emu;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         set_i = 1'b0;
    logic         reset_i = 1'b0;
    logic [W-1:0] d_i = '0;
    logic [W-1:0] q_o, qb_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    setreset_bank_emu #(.WIDTH(W)) u0 (
        .clk_i   (clk),
        .set_i   (set_i),
        .reset_i (reset_i),
        .d_i     (d_i),
        .q_o     (q_o),
        .qb_o    (qb_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] exp);
        nvec++;
        if (q_o !== exp || qb_o !== ~exp) begin
            nbad++;
            $display("FAIL %s: q=%h qb=%h expected q=%h qb=%h", tag, q_o, qb_o, exp, ~exp);
        end
    endtask

    // Move to the low phase of the clock, clear of any edge
    task automatic mid_low();
        @(negedge clk);
        #1;
    endtask

    task automatic load(input logic [W-1:0] v, input string tag);
        mid_low();
        d_i = v;
        @(posedge clk);
        #2;
        chk(tag, v);
    endtask

    task automatic t_reset_state();
        mid_low();
        reset_i = 1'b1; #1;
        chk("R2 reset applied", '0);
        reset_i = 1'b0; #1;
        chk("R5 after reset release", '0);
    endtask

    task automatic t_set_async();
        mid_low();
        d_i = 8'h5A;
        set_i = 1'b1; #1;
        chk("R1 set async", 8'hFF);
        @(posedge clk); #2;
        chk("R8 edge during set", 8'hFF);
        set_i = 1'b0; #1;
        chk("R5 after set release", 8'hFF);
    endtask

    task automatic t_both();
        mid_low();
        reset_i = 1'b1; #1;
        set_i = 1'b1; #1;
        chk("R3 both high", 8'hFF);
        set_i = 1'b0; #1;
        chk("R3 set dropped reset held", 8'h00);
        @(posedge clk); #2;
        chk("R8 edge during reset", 8'h00);
        reset_i = 1'b0; #1;
    endtask

    task automatic t_load_direct();
        mid_low();
        reset_i = 1'b1; #1; reset_i = 1'b0;
        load(8'hA5, "R4 load direct a");
        load(8'h3C, "R4 load direct b");
        load(8'hFF, "R4 load direct c");
    endtask

    task automatic t_load_invert();
        mid_low();
        set_i = 1'b1; #1; set_i = 1'b0;
        load(8'h00, "R4 load invert a");
        load(8'h96, "R4 load invert b");
        load(8'h01, "R4 load invert c");
    endtask

    task automatic t_hold();
        mid_low();
        d_i = 8'hE7; #2;
        chk("R5 d change no edge", 8'h01);
    endtask

    task automatic t_order();
        mid_low();
        d_i = 8'h42;
        reset_i = 1'b1; #1; reset_i = 1'b0; #1;
        set_i = 1'b1; #1; set_i = 1'b0; #1;
        chk("R6 clear then preset", 8'hFF);
        mid_low();
        set_i = 1'b1; #1; set_i = 1'b0; #1;
        reset_i = 1'b1; #1; reset_i = 1'b0; #1;
        chk("R6 preset then clear", 8'h00);
        load(8'h81, "R4 load after ordering");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset_state();
        t_set_async();
        t_both();
        t_load_direct();
        t_load_invert();
        t_hold();
        t_order();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule